// File: doc/BRIEF.md
# Multi-Vector Interrupt Controller for an 8-bit Core

This block gathers eleven interrupt events for a small 8-bit processor and turns them into a vectored request. Three sources have vectors of their own: the external pin, the timer-0 overflow and the timer clock-input edge. The other eight sources are the peripherals: port change, timer-1/2/3 overflow, transmit buffer empty, receive buffer full, capture 1 and capture 2. All eight share one vector. Every source has a pending flag and an enable bit. The peripheral group also has a group enable, and one global disable bit gates acceptance of any request.

When a request is accepted, the controller sets the global disable bit. It pulses a take strobe for one cycle and presents the vector address, so the core can push its return address and jump. A dedicated source has its flag cleared on entry. Peripheral flags stay set until software writes them to zero. A return strobe from the core clears the global disable bit. A wake output reports any enabled pending source, whatever the state of the global disable bit, so a sleeping core can resume.

Software reaches the flags and enables through a 2-bit-addressed, 8-bit register port. Writes are synchronous. Reads are combinational.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on an event input sets the matching flag at the next clock edge, whatever the state of its enable, the group enable or the global disable bit.
- R2: When a software write and an event hit the same flag in the same cycle, the flag ends up set.
- R3: When the global disable bit is clear and at least one vector is requesting, then in the following cycle take_o is high for exactly one cycle, vec_addr_o holds the chosen vector address, and the global disable bit reads 1.
- R4: When several vectors request at once, the grant order is external pin (default 0x0008), then timer-0 (0x0010), then clock-input edge (0x0018), then peripheral (0x0020).
- R5: Entry through a dedicated vector clears that source's flag and leaves the other dedicated flags unchanged.
- R6: Entry through the peripheral vector clears no flag. A peripheral flag that is still set and enabled is taken again once the global disable bit clears.
- R7: The peripheral summary (core register bit 6) is the OR of the peripheral flags ANDed with their enables. The peripheral vector requests only when both the summary and the group enable (core register bit 7) are 1.
- R8: A pulse on reti_i while the global disable bit is set clears it at the next clock edge.
- R9: wake_o is high whenever any dedicated source is flagged and enabled, or the peripheral summary and group enable are both 1. This holds even while the global disable bit is set.
- R10: Register map: select 0 holds core flags [2:0] (ext, tmr0, edge), core enables [5:3], the read-only summary [6] and the group enable [7]; select 1 holds peripheral flags; select 2 holds peripheral enables; select 3 holds the global disable bit [0]. After reset everything reads 0 except the global disable bit, which reads 1.
- R11: While the global disable bit is set, take_o stays low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_evt_i | input | 1 | External pin event pulse |
| tmr0_evt_i | input | 1 | Timer-0 overflow pulse |
| edge_evt_i | input | 1 | Timer clock-input edge pulse |
| peri_evt_i | input | NUM_PERI | Peripheral event pulses (bit 0 port change, 1..3 timers 1..3, 4 tx empty, 5 rx full, 6..7 captures) |
| reg_we_i | input | 1 | Register write strobe |
| reg_wsel_i | input | 2 | Write register select |
| reg_wdata_i | input | 8 | Write data |
| reg_rsel_i | input | 2 | Read register select |
| reg_rdata_o | output | 8 | Read data |
| reti_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | One-cycle take-interrupt strobe |
| vec_addr_o | output | ADDR_W | Vector address, valid with take_o |
| wake_o | output | 1 | Wake-up request |

## Verification
A flag that is wrongly cleared or never set shows up in the next read of its register. It also shows as a missing wake_o or take_o one clock after the disable bit opens. A wrong disable bit shows within one cycle, either as a second take_o strobe or as a missing one after a return. A wrong priority or a wrong auto-clear shows in the vector sequence of a chain of returns: a dedicated vector is taken twice, or the peripheral vector is not repeated. The bench compares take_o, vec_addr_o, wake_o and the selected read data against a behavioural model at every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NUM_DED = 3;
  localparam int NUM_VEC = NUM_DED + 1;
  localparam int DATA_W  = 8;

  typedef enum logic [1:0] {
    VEC_EXT  = 2'd0,
    VEC_TMR0 = 2'd1,
    VEC_EDGE = 2'd2,
    VEC_PERI = 2'd3
  } vec_e;

  typedef enum logic [1:0] {
    SEL_CORE  = 2'd0,
    SEL_PFLAG = 2'd1,
    SEL_PEN   = 2'd2,
    SEL_GCTL  = 2'd3
  } reg_sel_e;

  localparam int CORE_SUM_BIT = 6;
  localparam int CORE_PEN_BIT = 7;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] hw_clr_i,
  input  logic         wr_flag_i,
  input  logic [W-1:0] wflag_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wen_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] flag_q, en_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic flag_base;
    // write overrides auto-clear; event set overrides both
    assign flag_base = wr_flag_i ? wflag_i[i] : (flag_q[i] & ~hw_clr_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        flag_q[i] <= flag_base | set_i[i];
        if (wr_en_i) en_q[i] <= wen_i[i];
      end
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign pend_o = flag_q & en_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_ctrl_pkg::*;
(
  input  logic [NUM_VEC-1:0] req_i,
  output logic               valid_o,
  output vec_e               vec_o
);
  always_comb begin
    valid_o = |req_i;
    vec_o   = VEC_PERI;
    // lowest index wins
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (req_i[i]) vec_o = vec_e'(i[1:0]);
    end
  end
endmodule

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int                NUM_PERI  = 8,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] VEC_EXT_A = 16'h0008,
  parameter logic [ADDR_W-1:0] VEC_T0_A  = 16'h0010,
  parameter logic [ADDR_W-1:0] VEC_EDG_A = 16'h0018,
  parameter logic [ADDR_W-1:0] VEC_PER_A = 16'h0020
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ext_evt_i,
  input  logic                tmr0_evt_i,
  input  logic                edge_evt_i,
  input  logic [NUM_PERI-1:0] peri_evt_i,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_wsel_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  input  logic [1:0]          reg_rsel_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                reti_i,
  output logic                take_o,
  output logic [ADDR_W-1:0]   vec_addr_o,
  output logic                wake_o
);
  localparam int ENB_LO = NUM_DED;
  localparam int ENB_HI = 2 * NUM_DED - 1;

  logic [NUM_DED-1:0]  ded_set, ded_clr, ded_flag, ded_en, ded_pend;
  logic [NUM_PERI-1:0] peri_flag, peri_en, peri_pend;
  logic                wr_core, wr_pflag, wr_pen, wr_gctl;
  logic                pen_q, gdis_q, take_q;
  vec_e                vec_q, grant_vec;
  logic                grant_valid, peri_sum;
  logic [NUM_VEC-1:0]  req;

  assign wr_core  = reg_we_i && (reg_wsel_i == SEL_CORE);
  assign wr_pflag = reg_we_i && (reg_wsel_i == SEL_PFLAG);
  assign wr_pen   = reg_we_i && (reg_wsel_i == SEL_PEN);
  assign wr_gctl  = reg_we_i && (reg_wsel_i == SEL_GCTL);

  assign ded_set = {edge_evt_i, tmr0_evt_i, ext_evt_i};

  always_comb begin
    ded_clr = '0;
    if (grant_valid && grant_vec != VEC_PERI) ded_clr[grant_vec] = 1'b1;
  end

  irq_flag_bank #(.W(NUM_DED)) u_ded (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (ded_set),
    .hw_clr_i (ded_clr),
    .wr_flag_i(wr_core),
    .wflag_i  (reg_wdata_i[NUM_DED-1:0]),
    .wr_en_i  (wr_core),
    .wen_i    (reg_wdata_i[ENB_HI:ENB_LO]),
    .flag_o   (ded_flag),
    .en_o     (ded_en),
    .pend_o   (ded_pend)
  );

  irq_flag_bank #(.W(NUM_PERI)) u_peri (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (peri_evt_i),
    .hw_clr_i ('0),
    .wr_flag_i(wr_pflag),
    .wflag_i  (reg_wdata_i[NUM_PERI-1:0]),
    .wr_en_i  (wr_pen),
    .wen_i    (reg_wdata_i[NUM_PERI-1:0]),
    .flag_o   (peri_flag),
    .en_o     (peri_en),
    .pend_o   (peri_pend)
  );

  assign peri_sum = |peri_pend;
  assign req      = gdis_q ? '0 : {pen_q & peri_sum, ded_pend};

  irq_prio u_prio (
    .req_i  (req),
    .valid_o(grant_valid),
    .vec_o  (grant_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pen_q  <= 1'b0;
      gdis_q <= 1'b1;
      take_q <= 1'b0;
      vec_q  <= VEC_EXT;
    end else begin
      if (wr_core) pen_q <= reg_wdata_i[CORE_PEN_BIT];
      if (grant_valid)  gdis_q <= 1'b1;
      else if (reti_i)  gdis_q <= 1'b0;
      else if (wr_gctl) gdis_q <= reg_wdata_i[0];
      take_q <= grant_valid;
      if (grant_valid) vec_q <= grant_vec;
    end
  end

  always_comb begin
    unique case (vec_q)
      VEC_EXT:  vec_addr_o = VEC_EXT_A;
      VEC_TMR0: vec_addr_o = VEC_T0_A;
      VEC_EDGE: vec_addr_o = VEC_EDG_A;
      default:  vec_addr_o = VEC_PER_A;
    endcase
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_rsel_i)
      SEL_CORE: begin
        reg_rdata_o[NUM_DED-1:0]   = ded_flag;
        reg_rdata_o[ENB_HI:ENB_LO] = ded_en;
        reg_rdata_o[CORE_SUM_BIT]  = peri_sum;
        reg_rdata_o[CORE_PEN_BIT]  = pen_q;
      end
      SEL_PFLAG: reg_rdata_o[NUM_PERI-1:0] = peri_flag;
      SEL_PEN:   reg_rdata_o[NUM_PERI-1:0] = peri_en;
      default:   reg_rdata_o[0] = gdis_q;
    endcase
  end

  assign take_o = take_q;
  assign wake_o = (|ded_pend) | (pen_q & peri_sum);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_PERI = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                take_i,
  input logic                reti_i,
  input logic                gdis_i,
  input logic [NUM_PERI-1:0] peri_evt_i,
  input logic [NUM_PERI-1:0] peri_flag_i
);
  a_r3_take_sets_gdis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (gdis_i && !$past(gdis_i)));

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !take_i);

  a_r11_no_take_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gdis_i |=> !take_i);

  a_r8_reti_reenables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && gdis_i) |=> !gdis_i);

  a_r1_event_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|peri_evt_i) |=> ((peri_flag_i & $past(peri_evt_i)) == $past(peri_evt_i)));
endmodule

bind mcu_irq_ctrl irq_ctrl_chk #(.NUM_PERI(NUM_PERI)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .take_i     (take_o),
  .reti_i     (reti_i),
  .gdis_i     (gdis_q),
  .peri_evt_i (peri_evt_i),
  .peri_flag_i(peri_flag)
);

// File: tb/mcu_irq_ctrl_bench.sv
module mcu_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_evt = 0, tmr0_evt = 0, edge_evt = 0, reti = 0, we = 0;
  logic [7:0] peri_evt = '0, wdata = '0;
  logic [1:0] wsel = '0, rsel = '0;
  logic [7:0] rdata;
  logic take, wake;
  logic [15:0] vaddr;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mcu_irq_ctrl u_mcu_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .ext_evt_i(ext_evt), .tmr0_evt_i(tmr0_evt), .edge_evt_i(edge_evt),
    .peri_evt_i(peri_evt),
    .reg_we_i(we), .reg_wsel_i(wsel), .reg_wdata_i(wdata),
    .reg_rsel_i(rsel), .reg_rdata_o(rdata),
    .reti_i(reti), .take_o(take), .vec_addr_o(vaddr), .wake_o(wake)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit [2:0] m_df, m_de;
  bit [7:0] m_pf, m_pe;
  bit m_pen, m_gdis = 1, m_take;
  int m_vec;

  function automatic int m_read(input int s);
    case (s)
      0: return {m_pen, |(m_pf & m_pe), m_de, m_df};
      1: return m_pf;
      2: return m_pe;
      default: return m_gdis;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_df = 0; m_de = 0; m_pf = 0; m_pe = 0; m_pen = 0; m_gdis = 1; m_take = 0; m_vec = 0;
    end else begin
      bit [3:0] rq;
      int g;
      bit [2:0] df;
      rq = 0;
      if (!m_gdis) begin
        for (int i = 0; i < 3; i++) rq[i] = m_df[i] & m_de[i];
        rq[3] = m_pen && ((m_pf & m_pe) != 0);
      end
      g = -1;
      for (int i = 3; i >= 0; i--) if (rq[i]) g = i;
      df = m_df;
      if (g >= 0 && g < 3) df[g] = 0;
      if (we && wsel == 0) begin
        df = wdata[2:0]; m_de = wdata[5:3]; m_pen = wdata[7];
      end
      m_df = df | {edge_evt, tmr0_evt, ext_evt};
      if (we && wsel == 1) m_pf = wdata;
      m_pf = m_pf | peri_evt;
      if (we && wsel == 2) m_pe = wdata;
      if (g >= 0) m_gdis = 1;
      else if (reti) m_gdis = 0;
      else if (we && wsel == 3) m_gdis = wdata[0];
      m_take = (g >= 0);
      if (g >= 0) m_vec = 16'h0008 + 8 * g;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 model take", take, m_take);
      if (m_take) chk("R4 model vector", vaddr, m_vec);
      chk("R9 model wake", wake, m_wake());
      chk("R10 model read", rdata, m_read(rsel));
    end
  end

  function automatic int m_wake();
    return ((m_df & m_de) != 0) || (m_pen && ((m_pf & m_pe) != 0));
  endfunction

  task automatic wr(input int s, input int d);
    @(posedge clk); #2; we = 1; wsel = s[1:0]; wdata = d[7:0];
    @(posedge clk); #2; we = 0;
  endtask

  task automatic wr_evt(input int s, input int d, input int p);
    @(posedge clk); #2; we = 1; wsel = s[1:0]; wdata = d[7:0]; peri_evt = p[7:0];
    @(posedge clk); #2; we = 0; peri_evt = 0;
  endtask

  task automatic evt(input int ded, input int p);
    @(posedge clk); #2; {edge_evt, tmr0_evt, ext_evt} = ded[2:0]; peri_evt = p[7:0];
    @(posedge clk); #2; {edge_evt, tmr0_evt, ext_evt} = 0; peri_evt = 0;
  endtask

  task automatic do_reti();
    @(posedge clk); #2; reti = 1;
    @(posedge clk); #2; reti = 0;
  endtask

  task automatic rd_chk(input int s, input int exp, input string tag);
    @(posedge clk); #2; rsel = s[1:0];
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  task automatic wait_take(output bit seen);
    seen = 0;
    for (int i = 0; i < 6 && !seen; i++) begin
      @(negedge clk);
      if (take) seen = 1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    bit seen;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R10 reset state
    rd_chk(0, 8'h00, "R10 core reg after reset");
    rd_chk(1, 8'h00, "R10 peri flags after reset");
    rd_chk(2, 8'h00, "R10 peri enables after reset");
    rd_chk(3, 8'h01, "R10 global disable after reset");
    chk("R10 take after reset", take, 0);
    chk("R10 wake after reset", wake, 0);
    // R1 event sets flag with everything disabled
    evt(0, 8'h04);
    rd_chk(1, 8'h04, "R1 flag set while disabled");
    chk("R1 no wake when not enabled", wake, 0);
    // R2 set wins over clearing write
    wr_evt(1, 8'h00, 8'h20);
    rd_chk(1, 8'h20, "R2 event beats write");
    // R7 / R9 summary and wake with global disable set
    wr(2, 8'h20);
    wr(0, 8'h80);
    rd_chk(0, 8'hC0, "R7 summary and group enable");
    chk("R9 wake while globally disabled", wake, 1);
    wait_take(seen);
    chk("R11 no take while disabled", seen, 0);
    // prepare all vectors pending at once
    wr(1, 8'h00);
    wr(2, 8'h01);
    wr(0, 8'hB8);
    evt(3'b111, 8'h01);
    wr(3, 8'h00);
    wait_take(seen);
    chk("R3 take after enable", seen, 1);
    chk("R4 first vector ext", vaddr, 16'h0008);
    rd_chk(3, 8'h01, "R3 disable set on take");
    rd_chk(0, 8'hFE, "R5 ext flag cleared");
    do_reti();
    wait_take(seen);
    chk("R4 second vector tmr0", vaddr, 16'h0010);
    rd_chk(0, 8'hFC, "R5 tmr0 flag cleared");
    do_reti();
    wait_take(seen);
    chk("R4 third vector edge", vaddr, 16'h0018);
    rd_chk(0, 8'hF8, "R5 edge flag cleared");
    do_reti();
    wait_take(seen);
    chk("R4 fourth vector peripheral", vaddr, 16'h0020);
    rd_chk(1, 8'h01, "R6 peri flag kept after take");
    do_reti();
    wait_take(seen);
    chk("R6 peripheral retaken", seen, 1);
    chk("R6 peripheral vector again", vaddr, 16'h0020);
    wr(1, 8'h00);
    do_reti();
    rd_chk(3, 8'h00, "R8 reti clears disable");
    wait_take(seen);
    chk("R8 nothing pending after reti", seen, 0);
    rd_chk(0, 8'hB8, "R7 summary clear");
    chk("R9 wake low when nothing pending", wake, 0);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule